// File: doc/BRIEF.md
# Watchdog Timer with Keyed Stop Sequence

This block is a watchdog peripheral that sits on a simple single-cycle register bus. It starts counting the moment it leaves reset. When the count runs out, it raises a one-cycle reset request toward the system and reloads the count. Software can halt it only by writing two magic words, in the right order, to a key register. A second ordered pair of words starts it again. Every key write, and every write of a new timeout value, passes through a fixed-length pending window before it takes effect. Software polls a pending register to learn when that window has ended.

Writing a control bit starts a module soft reset. While the soft reset runs for a fixed number of cycles, the block holds every piece of its state at its reset value. A done bit reads low for that whole span. When the soft reset ends, the watchdog is armed again exactly as after a hardware reset.

The bus has no back-pressure. A write with `bus_sel` and `bus_we` high is taken in the cycle it appears. Reads are combinational from `bus_addr` while `bus_sel` is high and `bus_we` is low, and the bus reads zero otherwise. Software paces itself by polling the pending flags rather than by being stalled.

Top module: `wdt_guard`

## Requirements
- R1: After hardware reset the following read values hold. CTRL (0x10) reads 0. STAT (0x14) bit 0 reads 1. LOAD (0x28) holds DEFAULT_LOAD. PEND (0x34) reads 0. KEY (0x48) bit 0, the running flag, reads 1.
- R2: While running, the count in COUNT (0x2C) drops by one every PRESCALE cycles. When the count is 0 on a tick, `wd_rst_req` is high for exactly one cycle and the count reloads from LOAD. Successive requests are therefore (LOAD+1)*PRESCALE cycles apart.
- R3: Writing 0x0000AAAA to KEY and then 0x00005555, each after the previous pending window has ended, stops the counter. The running flag reads 0, COUNT holds still and no request is raised.
- R4: After 0x0000AAAA, any other value returns the key sequencer to idle. In that case a following 0x00005555 does not stop the counter.
- R5: Writing 0x0000BBBB and then 0x00004444 to KEY restarts a stopped counter.
- R6: PEND bit 4 is high for exactly PEND_CYC cycles after an accepted KEY write. The write takes effect when the bit falls. KEY writes made while bit 4 is high are dropped and do not lengthen the window.
- R7: A LOAD write while the counter is stopped raises PEND bit 2 for PEND_CYC cycles and then sets both LOAD and COUNT to the written value. A LOAD write while running is dropped: bit 2 stays 0 and LOAD is unchanged.
- R8: Writing 1 to CTRL bit 1 starts a soft reset. During the soft reset, STAT bit 0 reads 0 and CTRL bit 1 reads 1 for SRST_CYC cycles, after which CTRL bit 1 clears by itself. Afterwards the block is as in R1: running, LOAD at its default and the key sequencer idle.
- R9: Bus writes made while a soft reset is in progress have no effect.
- R10: Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wd_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
Two pending windows can be open in the same cycle, one for a key write and one for a timeout write. The bench provokes this with the counter stopped: it writes a neutral key word and, in the very next bus cycle, a new LOAD value. It then reads PEND and expects both bit 4 and bit 2 high at once. After both windows close, it checks that LOAD and COUNT carry the new value. A second overlap is a soft reset that lands while a key write is being issued. The bench judges this one by PEND reading 0 during the soft reset and by the running flag being unchanged afterwards.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_LOAD  = 8'h28;
  localparam logic [7:0] OFS_COUNT = 8'h2C;
  localparam logic [7:0] OFS_PEND  = 8'h34;
  localparam logic [7:0] OFS_KEY   = 8'h48;

  localparam int unsigned BIT_SRST      = 1;
  localparam int unsigned BIT_DONE      = 0;
  localparam int unsigned BIT_RUN       = 0;
  localparam int unsigned BIT_PEND_LOAD = 2;
  localparam int unsigned BIT_PEND_KEY  = 4;

  localparam logic [REG_W-1:0] KEY_STOP_1 = 32'h0000_AAAA;
  localparam logic [REG_W-1:0] KEY_STOP_2 = 32'h0000_5555;
  localparam logic [REG_W-1:0] KEY_RUN_1  = 32'h0000_BBBB;
  localparam logic [REG_W-1:0] KEY_RUN_2  = 32'h0000_4444;

  typedef enum logic [1:0] {
    KS_IDLE     = 2'd0,
    KS_STOP_ARM = 2'd1,
    KS_RUN_ARM  = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdt_guard_srst.sv
module wdt_guard_srst #(
  parameter int unsigned SRST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned SW = $clog2(SRST_CYC + 1);

  logic [SW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else if (start) begin
      remain <= SW'(SRST_CYC);
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/wdt_guard_key.sv
module wdt_guard_key
  import wdt_guard_pkg::*;
#(
  parameter int unsigned PEND_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  output logic             pend,
  output logic             run
);
  localparam int unsigned PW = $clog2(PEND_CYC + 1);

  logic [PW-1:0]    wait_cnt;
  logic [REG_W-1:0] staged;
  key_state_e       state;
  logic             apply;

  assign apply = (wait_cnt == PW'(1));
  assign pend  = (wait_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      staged   <= '0;
      state    <= KS_IDLE;
      run      <= 1'b1;
    end else if (clr) begin
      wait_cnt <= '0;
      staged   <= '0;
      state    <= KS_IDLE;
      run      <= 1'b1;
    end else begin
      if (pend) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else if (wr_stb) begin
        wait_cnt <= PW'(PEND_CYC);
        staged   <= wdata;
      end
      if (apply) begin
        if (staged == KEY_STOP_1) begin
          state <= KS_STOP_ARM;
        end else if (staged == KEY_RUN_1) begin
          state <= KS_RUN_ARM;
        end else begin
          state <= KS_IDLE;
          if (state == KS_STOP_ARM && staged == KEY_STOP_2) run <= 1'b0;
          if (state == KS_RUN_ARM && staged == KEY_RUN_2)   run <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_guard_cnt.sv
module wdt_guard_cnt #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned DEFAULT_LOAD = 200,
  parameter int unsigned PRESCALE     = 4,
  parameter int unsigned PEND_CYC     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_data,
  output logic             load_pend,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int unsigned PW = $clog2(PEND_CYC + 1);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(DEFAULT_LOAD);

  logic             tick;
  logic [PW-1:0]    lwait;
  logic [CNT_W-1:0] lstage;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run && !clr;
    end else begin : g_div
      localparam int unsigned DW = $clog2(PRESCALE);
      logic [DW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre <= '0;
        end else if (clr || !run || pre == DW'(PRESCALE - 1)) begin
          pre <= '0;
        end else begin
          pre <= pre + 1'b1;
        end
      end
      assign tick = run && !clr && (pre == DW'(PRESCALE - 1));
    end
  endgenerate

  assign load_pend = (lwait != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lwait  <= '0;
      lstage <= '0;
      load_q <= INIT;
      count  <= INIT;
      expire <= 1'b0;
    end else if (clr) begin
      lwait  <= '0;
      lstage <= '0;
      load_q <= INIT;
      count  <= INIT;
      expire <= 1'b0;
    end else begin
      expire <= tick && (count == '0);
      if (load_pend) begin
        lwait <= lwait - 1'b1;
      end else if (load_stb && !run) begin
        lwait  <= PW'(PEND_CYC);
        lstage <= load_data;
      end
      if (lwait == PW'(1) && !run) begin
        load_q <= lstage;
        count  <= lstage;
      end else if (tick) begin
        count <= (count == '0) ? load_q : count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned DEFAULT_LOAD = 200,
  parameter int unsigned PRESCALE     = 4,
  parameter int unsigned PEND_CYC     = 4,
  parameter int unsigned SRST_CYC     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wd_rst_req
);
  logic             srst_busy;
  logic             wr_ok;
  logic             key_wr;
  logic             load_wr;
  logic             srst_go;
  logic             key_pend;
  logic             load_pend;
  logic             run_en;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count;

  assign wr_ok   = bus_sel && bus_we && !srst_busy;
  assign key_wr  = wr_ok && (bus_addr == ADDR_W'(OFS_KEY));
  assign load_wr = wr_ok && (bus_addr == ADDR_W'(OFS_LOAD));
  assign srst_go = wr_ok && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[BIT_SRST];

  wdt_guard_srst #(.SRST_CYC(SRST_CYC)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_go),
    .busy  (srst_busy)
  );

  wdt_guard_key #(.PEND_CYC(PEND_CYC)) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (srst_busy),
    .wr_stb (key_wr),
    .wdata  (bus_wdata),
    .pend   (key_pend),
    .run    (run_en)
  );

  wdt_guard_cnt #(
    .CNT_W        (CNT_W),
    .DEFAULT_LOAD (DEFAULT_LOAD),
    .PRESCALE     (PRESCALE),
    .PEND_CYC     (PEND_CYC)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (srst_busy),
    .run       (run_en),
    .load_stb  (load_wr),
    .load_data (bus_wdata[CNT_W-1:0]),
    .load_pend (load_pend),
    .load_q    (load_q),
    .count     (count),
    .expire    (wd_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL):  bus_rdata[BIT_SRST] = srst_busy;
        ADDR_W'(OFS_STAT):  bus_rdata[BIT_DONE] = !srst_busy;
        ADDR_W'(OFS_LOAD):  bus_rdata = 32'(load_q);
        ADDR_W'(OFS_COUNT): bus_rdata = 32'(count);
        ADDR_W'(OFS_PEND): begin
          bus_rdata[BIT_PEND_KEY]  = key_pend;
          bus_rdata[BIT_PEND_LOAD] = load_pend;
        end
        ADDR_W'(OFS_KEY):   bus_rdata[BIT_RUN] = run_en;
        default:            bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic key_wr,
  input logic key_pend,
  input logic load_pend,
  input logic run,
  input logic rst_req
);
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(run)); // R2

  AST_RUN_MOVES_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> ($past(key_pend) || $past(busy))); // R3

  AST_KEY_PEND_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !key_pend) |=> key_pend); // R6

  AST_LOAD_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_pend) |-> !$past(run)); // R7

  AST_SRST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> run); // R8

  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (!key_pend && !load_pend && !rst_req)); // R9
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (srst_busy),
  .key_wr    (key_wr),
  .key_pend  (key_pend),
  .load_pend (load_pend),
  .run       (run_en),
  .rst_req   (wd_rst_req)
);

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;
  import wdt_guard_pkg::*;

  localparam int unsigned DEF_LOAD = 9;
  localparam int unsigned PRE      = 2;
  localparam int unsigned PCYC     = 4;
  localparam int unsigned SCYC     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int req_seen = 0;

  always #2 clk = ~clk;

  wdt_guard #(
    .ADDR_W(8), .CNT_W(16), .DEFAULT_LOAD(DEF_LOAD),
    .PRESCALE(PRE), .PEND_CYC(PCYC), .SRST_CYC(SCYC)
  ) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_req(wd_rst_req)
  );

  always @(negedge clk) if (rst_n && wd_rst_req) req_seen++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_clear(input int b);
    logic [31:0] v;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rd(OFS_PEND, v);
      if (!v[b]) break;
    end
  endtask

  task automatic key(input logic [31:0] d);
    wr(OFS_KEY, d);
    wait_clear(BIT_PEND_KEY);
  endtask

  task automatic count_high(input int b, output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 16; i++) begin
      rd(OFS_PEND, v);
      if (v[b]) n++;
      @(negedge clk);
    end
  endtask

  task automatic period(output int n);
    n = 0;
    for (int i = 0; i < 400 && !wd_rst_req; i++) @(negedge clk);
    @(negedge clk);
    n = 1;
    for (int i = 0; i < 400 && !wd_rst_req; i++) begin
      @(negedge clk);
      n++;
    end
    if (!wd_rst_req) n = -1;
  endtask

  task automatic step_check(input string req, input int load, input bit moving);
    logic [31:0] c1, c2;
    int exp;
    @(negedge clk);
    rd(OFS_COUNT, c1);
    repeat (6) @(negedge clk);
    rd(OFS_COUNT, c2);
    exp = moving ? int'((c1 + (load + 1) - (3 % (load + 1))) % (load + 1)) : int'(c1);
    check(c2 == exp, req, c2, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(OFS_CTRL, v);  check(v == 0, "R1 ctrl", v, 0);
    rd(OFS_STAT, v);  check(v == 1, "R1 stat", v, 1);
    rd(OFS_LOAD, v);  check(v == DEF_LOAD, "R1 load", v, DEF_LOAD);
    rd(OFS_PEND, v);  check(v == 0, "R1 pend", v, 0);
    rd(OFS_KEY, v);   check(v == 1, "R1 run", v, 1);
    // R10 unmapped
    rd(8'h00, v);     check(v == 0, "R10 unmapped", v, 0);
    rd(8'h44, v);     check(v == 0, "R10 unmapped", v, 0);

    // R2 period and stepping
    period(n); check(n == (DEF_LOAD + 1) * PRE, "R2 period", n, (DEF_LOAD + 1) * PRE);
    step_check("R2 step", DEF_LOAD, 1'b1);

    // R6 window length, R3 stop
    wr(OFS_KEY, KEY_STOP_1);
    count_high(BIT_PEND_KEY, n); check(n == PCYC, "R6 window", n, PCYC);
    key(KEY_STOP_2);
    rd(OFS_KEY, v); check(v == 0, "R3 stopped", v, 0);
    step_check("R3 frozen", DEF_LOAD, 1'b0);
    seen = req_seen;
    repeat (60) @(negedge clk);
    check(req_seen == seen, "R3 no request", req_seen - seen, 0);

    // R5 restart
    key(KEY_RUN_1); key(KEY_RUN_2);
    rd(OFS_KEY, v); check(v == 1, "R5 running", v, 1);
    step_check("R5 moving", DEF_LOAD, 1'b1);

    // R4 broken sequence
    key(KEY_STOP_1); key(32'h0000_1234); key(KEY_STOP_2);
    rd(OFS_KEY, v); check(v == 1, "R4 still running", v, 1);
    key(KEY_RUN_1); key(KEY_STOP_2);
    rd(OFS_KEY, v); check(v == 1, "R4 wrong pair", v, 1);

    // R6 write during window ignored
    wr(OFS_KEY, KEY_STOP_1);
    wr(OFS_KEY, 32'h0000_1234);
    count_high(BIT_PEND_KEY, n); check(n == PCYC - 2, "R6 no extend", n, PCYC - 2);
    key(KEY_STOP_2);
    rd(OFS_KEY, v); check(v == 0, "R6 dropped write", v, 0);

    // both windows open together
    wr(OFS_KEY, 32'h0000_1234);
    wr(OFS_LOAD, 32'd5);
    rd(OFS_PEND, v); check(v == 32'h14, "R6 R7 both pending", v, 32'h14);
    wait_clear(BIT_PEND_KEY); wait_clear(BIT_PEND_LOAD);
    rd(OFS_LOAD, v);  check(v == 5, "R7 load", v, 5);
    rd(OFS_COUNT, v); check(v == 5, "R7 count", v, 5);

    // R7 sweep of timeouts
    for (int i = 0; i < 5; i++) begin
      automatic int ld = (i == 4) ? 11 : ((i == 3) ? 6 : i + 1);
      wr(OFS_LOAD, ld);
      count_high(BIT_PEND_LOAD, n); check(n == PCYC, "R7 window", n, PCYC);
      rd(OFS_LOAD, v);  check(v == ld, "R7 load sweep", v, ld);
      rd(OFS_COUNT, v); check(v == ld, "R7 count sweep", v, ld);
      key(KEY_RUN_1); key(KEY_RUN_2);
      period(n); check(n == (ld + 1) * PRE, "R2 R7 period", n, (ld + 1) * PRE);
      if (i != 4) begin key(KEY_STOP_1); key(KEY_STOP_2); end
    end
    // R7 ignored while running
    wr(OFS_LOAD, 32'd3);
    rd(OFS_PEND, v); check(v[BIT_PEND_LOAD] == 0, "R7 no window", v, 0);
    repeat (8) @(negedge clk);
    rd(OFS_LOAD, v); check(v == 11, "R7 ignored", v, 11);

    // R8 soft reset
    key(KEY_STOP_1);
    wr(OFS_CTRL, 32'h2);
    rd(OFS_CTRL, v); check(v == 2, "R8 ctrl busy", v, 2);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      rd(OFS_STAT, v);
      if (v[BIT_DONE] == 0) n++;
      @(negedge clk);
    end
    check(n == SCYC, "R8 done low span", n, SCYC);
    rd(OFS_CTRL, v); check(v == 0, "R8 ctrl clear", v, 0);
    rd(OFS_LOAD, v); check(v == DEF_LOAD, "R8 load default", v, DEF_LOAD);
    key(KEY_STOP_2);
    rd(OFS_KEY, v); check(v == 1, "R8 sequencer idle", v, 1);
    period(n); check(n == (DEF_LOAD + 1) * PRE, "R8 period", n, (DEF_LOAD + 1) * PRE);

    // R9 writes during soft reset
    key(KEY_STOP_1); key(KEY_STOP_2);
    wr(OFS_CTRL, 32'h2);
    wr(OFS_KEY, KEY_STOP_1);
    rd(OFS_PEND, v); check(v == 0, "R9 key dropped", v, 0);
    repeat (SCYC + 2) @(negedge clk);
    key(KEY_STOP_2);
    rd(OFS_KEY, v); check(v == 1, "R9 no stop armed", v, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule